// File: doc/BRIEF.md
# Vector Logic and Arithmetic Unit

This unit holds a 128-entry register file of 32-bit words and runs one element-wise logic or arithmetic instruction at a time over runs of consecutive registers. An instruction names a first operand register A, a destination D and a second operand B. B is read in one of three ways: as a vector that advances along with A, as one fixed scalar register, or as a 7-bit signed constant taken from the B field itself. The logic group offers AND, XOR and OR. The arithmetic group offers add, subtract, a reduction sum and a sign-steered add/subtract that yields an absolute value when A is register 0.

A host loads and inspects registers through a simple write port and a combinational read port while the unit is idle. It then presents a 32-bit instruction word with a one-cycle start strobe. The unit processes one element per clock, holds busy for the length of the run, and pulses done once it finishes. Register 0 is hard-wired to zero.

Top module: `vec_alu_unit`

## Requirements
- R1: After reset, busy and done are 0 and every register reads 0 on the host read port.
- R2: Register 0 always reads 0; writes to it from the host port or from an instruction are discarded.
- R3: Instruction word layout: bits 31:28 group (0xB logic, 0xA arithmetic), 27:24 element count minus one, 23:21 op code, 20:14 register A, 13:7 register D, 6:0 field B. A start while idle with any other group value is ignored: busy stays 0, no register changes and done does not pulse.
- R4: Logic op codes: 0 AND vector, 1 AND scalar, 2 AND immediate, 3 XOR vector, 4 XOR scalar, 5 XOR immediate, 6 OR vector, 7 OR scalar.
- R5: Arithmetic op codes: 0 add vector, 1 add scalar, 2 add immediate, 4 subtract vector (A minus B), 5 subtract scalar, 6 subtract immediate; results wrap modulo 2^32.
- R6: In immediate modes the 7-bit B field is sign-extended to 32 bits (0x7E means -2, 0x40 means -64).
- R7: Element i reads A+i and writes D+i; in vector modes B+i is read, in scalar modes B stays fixed; all register indices wrap modulo 128.
- R8: Arithmetic op 3 (sum) writes the single register D with R[B] plus the sum of R[A+i] over all elements; no other register is written.
- R9: Arithmetic op 7 (vector B) writes D+i with R[A+i] minus R[B+i] when R[B+i] is negative and R[A+i] plus R[B+i] otherwise.
- R10: An accepted start raises busy at the next edge; busy stays high for exactly count cycles; done is high for exactly one cycle, the cycle after the last element is written, and busy is low in that cycle.
- R11: While busy, host writes and further start strobes are ignored.
- R12: Elements are processed in ascending order, so an element whose A register is the destination of an earlier element of the same instruction reads the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the instruction on instr (sampled while idle) |
| instr | input | 32 | Instruction word |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| host_we | input | 1 | Host register write enable (idle only) |
| host_waddr | input | 7 | Host write register index |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 7 | Host read register index |
| host_rdata | output | 32 | Register contents at host_raddr |

## Verification
The assertions assume that start is only raised once the two-stage reset synchronizer has released, and that instr is stable in any cycle where start is high; the bench raises start only several cycles after reset and drives instr and start together on the falling edge. The completion properties take for granted that the count field never exceeds sixteen elements, which the four-bit field enforces. Directed scenarios cover every op code, immediates of both signs, index wrap through register 0, an in-place chain, a rejected group value and traffic injected mid-run, each compared against an independent register model.

// File: rtl/vla_pkg.sv
package vla_pkg;
  localparam int INSTR_W = 32;
  localparam int RIDX_W  = 7;
  localparam int CNT_W   = 4;
  localparam int OP_W    = 3;
  localparam int GRP_W   = 4;
  localparam int B_LSB   = 0;
  localparam int D_LSB   = 7;
  localparam int A_LSB   = 14;
  localparam int OP_LSB  = 21;
  localparam int CNT_LSB = 24;
  localparam int GRP_LSB = 28;
  localparam logic [GRP_W-1:0] GRP_LOGIC = 4'hB;
  localparam logic [GRP_W-1:0] GRP_ARITH = 4'hA;

  typedef enum logic [1:0] {BSRC_VEC, BSRC_SCL, BSRC_IMM} bsrc_e;
  typedef enum logic [2:0] {FN_AND, FN_XOR, FN_OR, FN_ADD, FN_SUB, FN_SUM, FN_ABS} fn_e;

  typedef struct packed {
    fn_e               fn;
    bsrc_e             bsrc;
    logic [RIDX_W-1:0] a_idx;
    logic [RIDX_W-1:0] d_idx;
    logic [RIDX_W-1:0] b_idx;
    logic [CNT_W-1:0]  last_el;
  } cmd_t;
endpackage

// File: rtl/vla_decode.sv
module vla_decode
  import vla_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output cmd_t               cmd,
  output logic               legal
);
  logic [GRP_W-1:0] grp;
  logic [OP_W-1:0]  op;

  assign grp = instr[GRP_LSB +: GRP_W];
  assign op  = instr[OP_LSB +: OP_W];

  always_comb begin
    cmd.a_idx   = instr[A_LSB +: RIDX_W];
    cmd.d_idx   = instr[D_LSB +: RIDX_W];
    cmd.b_idx   = instr[B_LSB +: RIDX_W];
    cmd.last_el = instr[CNT_LSB +: CNT_W];
    cmd.fn      = FN_AND;
    cmd.bsrc    = BSRC_VEC;
    legal       = 1'b0;
    if (grp == GRP_LOGIC) begin
      legal = 1'b1;
      case (op)
        3'd0: begin cmd.fn = FN_AND; cmd.bsrc = BSRC_VEC; end
        3'd1: begin cmd.fn = FN_AND; cmd.bsrc = BSRC_SCL; end
        3'd2: begin cmd.fn = FN_AND; cmd.bsrc = BSRC_IMM; end
        3'd3: begin cmd.fn = FN_XOR; cmd.bsrc = BSRC_VEC; end
        3'd4: begin cmd.fn = FN_XOR; cmd.bsrc = BSRC_SCL; end
        3'd5: begin cmd.fn = FN_XOR; cmd.bsrc = BSRC_IMM; end
        3'd6: begin cmd.fn = FN_OR;  cmd.bsrc = BSRC_VEC; end
        default: begin cmd.fn = FN_OR; cmd.bsrc = BSRC_SCL; end
      endcase
    end else if (grp == GRP_ARITH) begin
      legal = 1'b1;
      case (op)
        3'd0: begin cmd.fn = FN_ADD; cmd.bsrc = BSRC_VEC; end
        3'd1: begin cmd.fn = FN_ADD; cmd.bsrc = BSRC_SCL; end
        3'd2: begin cmd.fn = FN_ADD; cmd.bsrc = BSRC_IMM; end
        3'd3: begin cmd.fn = FN_SUM; cmd.bsrc = BSRC_SCL; end
        3'd4: begin cmd.fn = FN_SUB; cmd.bsrc = BSRC_VEC; end
        3'd5: begin cmd.fn = FN_SUB; cmd.bsrc = BSRC_SCL; end
        3'd6: begin cmd.fn = FN_SUB; cmd.bsrc = BSRC_IMM; end
        default: begin cmd.fn = FN_ABS; cmd.bsrc = BSRC_VEC; end
      endcase
    end
  end
endmodule

// File: rtl/vla_exec.sv
module vla_exec
  import vla_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fn_e               fn,
  input  bsrc_e             bsrc,
  input  logic [RIDX_W-1:0] imm,
  input  logic              first_el,
  input  logic [DATA_W-1:0] a_val,
  input  logic [DATA_W-1:0] b_val,
  input  logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] result
);
  localparam int EXT_W = DATA_W - RIDX_W;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] b_op;
  logic [DATA_W-1:0] sum_base;

  assign imm_ext  = {{EXT_W{imm[RIDX_W-1]}}, imm};
  assign b_op     = (bsrc == BSRC_IMM) ? imm_ext : b_val;
  assign sum_base = first_el ? b_op : acc;

  always_comb begin
    case (fn)
      FN_AND:  result = a_val & b_op;
      FN_XOR:  result = a_val ^ b_op;
      FN_OR:   result = a_val | b_op;
      FN_ADD:  result = a_val + b_op;
      FN_SUB:  result = a_val - b_op;
      FN_SUM:  result = sum_base + a_val;
      FN_ABS:  result = b_op[DATA_W-1] ? (a_val - b_op) : (a_val + b_op);
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/vla_seq.sv
module vla_seq
  import vla_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              legal,
  input  cmd_t              cmd_in,
  input  logic [DATA_W-1:0] result,
  output logic              busy,
  output logic              done,
  output cmd_t              cmd_cur,
  output logic              first_el,
  output logic              eng_we,
  output logic [RIDX_W-1:0] a_addr,
  output logic [RIDX_W-1:0] b_addr,
  output logic [RIDX_W-1:0] d_addr,
  output logic [DATA_W-1:0] acc
);
  localparam int PAD_W = RIDX_W - CNT_W;

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic              idx_en;
  cmd_t              cmd_q;
  logic              accept;
  logic              last_now;
  logic [DATA_W-1:0] acc_q;
  logic              acc_en;
  logic [RIDX_W-1:0] idx_ext;

  assign accept   = !busy_q && start && legal;
  assign last_now = busy_q && (idx_q == cmd_q.last_el);
  assign idx_ext  = {{PAD_W{1'b0}}, idx_q};
  assign acc_en   = busy_q;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    idx_d  = idx_q;
    idx_en = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
      idx_en = 1'b1;
    end else if (last_now) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else if (busy_q) begin
      idx_d  = idx_q + 1'b1;
      idx_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (accept) cmd_q <= cmd_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= result;
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign cmd_cur  = cmd_q;
  assign acc      = acc_q;
  assign first_el = (idx_q == '0);
  assign a_addr   = cmd_q.a_idx + idx_ext;
  assign b_addr   = (cmd_q.bsrc == BSRC_VEC) ? (cmd_q.b_idx + idx_ext) : cmd_q.b_idx;
  assign d_addr   = (cmd_q.fn == FN_SUM) ? cmd_q.d_idx : (cmd_q.d_idx + idx_ext);
  assign eng_we   = busy_q && ((cmd_q.fn != FN_SUM) || last_now);
endmodule

// File: rtl/vla_regfile.sv
module vla_regfile #(
  parameter int DATA_W = 32,
  parameter int REG_N  = 128,
  localparam int AW    = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [AW-1:0]     rb_addr,
  output logic [DATA_W-1:0] rb_data,
  input  logic [AW-1:0]     rh_addr,
  output logic [DATA_W-1:0] rh_data
);
  logic [DATA_W-1:0] rd_tab [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_ent
    if (g == 0) begin : g_zero
      assign rd_tab[g] = '0;
    end else begin : g_reg
      logic              ent_en;
      logic [DATA_W-1:0] ent_q;
      assign ent_en = we && (waddr == AW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ent_q <= '0;
        else if (ent_en) ent_q <= wdata;
      end
      assign rd_tab[g] = ent_q;
    end
  end

  assign ra_data = rd_tab[ra_addr];
  assign rb_data = rd_tab[rb_addr];
  assign rh_data = rd_tab[rh_addr];
endmodule

// File: rtl/vec_alu_unit.sv
module vec_alu_unit
  import vla_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  output logic               busy,
  output logic               done,
  input  logic               host_we,
  input  logic [RIDX_W-1:0]  host_waddr,
  input  logic [DATA_W-1:0]  host_wdata,
  input  logic [RIDX_W-1:0]  host_raddr,
  output logic [DATA_W-1:0]  host_rdata
);
  localparam int REG_N = 1 << RIDX_W;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  cmd_t              dec_cmd;
  logic              dec_legal;
  cmd_t              cmd_cur;
  logic              first_el;
  logic              eng_we;
  logic [RIDX_W-1:0] a_addr, b_addr, d_addr;
  logic [DATA_W-1:0] a_val, b_val, acc, result;
  logic              rf_we;
  logic [RIDX_W-1:0] rf_waddr;
  logic [DATA_W-1:0] rf_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  vla_decode u_dec (
    .instr (instr),
    .cmd   (dec_cmd),
    .legal (dec_legal)
  );

  vla_seq #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .legal    (dec_legal),
    .cmd_in   (dec_cmd),
    .result   (result),
    .busy     (busy),
    .done     (done),
    .cmd_cur  (cmd_cur),
    .first_el (first_el),
    .eng_we   (eng_we),
    .a_addr   (a_addr),
    .b_addr   (b_addr),
    .d_addr   (d_addr),
    .acc      (acc)
  );

  vla_exec #(.DATA_W(DATA_W)) u_exec (
    .fn       (cmd_cur.fn),
    .bsrc     (cmd_cur.bsrc),
    .imm      (cmd_cur.b_idx),
    .first_el (first_el),
    .a_val    (a_val),
    .b_val    (b_val),
    .acc      (acc),
    .result   (result)
  );

  // Engine owns the write port while busy; host writes are dropped then.
  assign rf_we    = busy ? eng_we : host_we;
  assign rf_waddr = busy ? d_addr : host_waddr;
  assign rf_wdata = busy ? result : host_wdata;

  vla_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_rf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .ra_addr (a_addr),
    .ra_data (a_val),
    .rb_addr (b_addr),
    .rb_data (b_val),
    .rh_addr (host_raddr),
    .rh_data (host_rdata)
  );
endmodule

// File: rtl/vla_checker.sv
module vla_checker #(
  parameter int DATA_W = 32,
  parameter int AW     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [3:0]        grp,
  input logic              busy,
  input logic              done,
  input logic [AW-1:0]     host_raddr,
  input logic [DATA_W-1:0] host_rdata
);
  logic grp_ok;
  assign grp_ok = (grp == 4'hA) || (grp == 4'hB);

  p_reg0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_raddr == '0) |-> (host_rdata == '0));

  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && grp_ok) |=> busy);

  p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !grp_ok) |=> !busy);

  p_done_after_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
endmodule

bind vec_alu_unit vla_checker #(.DATA_W(DATA_W), .AW(vla_pkg::RIDX_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start      (start),
  .grp        (instr[31:28]),
  .busy       (busy),
  .done       (done),
  .host_raddr (host_raddr),
  .host_rdata (host_rdata)
);

// File: tb/vec_alu_unit_tb_top.sv
`timescale 1ns/1ps
module vec_alu_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic        busy, done;
  logic        host_we = 1'b0;
  logic [6:0]  host_waddr = '0;
  logic [31:0] host_wdata = '0;
  logic [6:0]  host_raddr = '0;
  logic [31:0] host_rdata;

  int tests_run = 0;
  int tests_failed = 0;
  logic [31:0] exp_rf [128];

  always #10 clk = ~clk;

  vec_alu_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .busy(busy), .done(done),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata)
  );

  initial begin
    #3000000;
    tests_failed++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  function automatic logic [31:0] mk(input logic [3:0] grp, input int n,
      input logic [2:0] op, input logic [6:0] a, input logic [6:0] d, input logic [6:0] b);
    logic [3:0] c;
    c = 4'(n - 1);
    return {grp, c, op, a, d, b};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic mwr(input int r, input logic [31:0] v);
    if (r != 0) exp_rf[r] = v;
  endtask

  // Independent model of one instruction, built from the requirements.
  task automatic model(input logic [31:0] w);
    logic [3:0] g; logic [2:0] op; int n, a, d, b;
    logic [31:0] av, bv, rv, immv, s;
    bit vec, imm;
    g = w[31:28]; op = w[23:21]; n = int'(w[27:24]) + 1;
    a = int'(w[20:14]); d = int'(w[13:7]); b = int'(w[6:0]);
    immv = {{25{w[6]}}, w[6:0]};
    if (g != 4'hA && g != 4'hB) return;
    if (g == 4'hA && op == 3'd3) begin
      s = exp_rf[b];
      for (int i = 0; i < n; i++) s = s + exp_rf[(a + i) % 128];
      mwr(d, s);
      return;
    end
    if (g == 4'hB) begin
      vec = (op == 0 || op == 3 || op == 6); imm = (op == 2 || op == 5);
    end else begin
      vec = (op == 0 || op == 4 || op == 7); imm = (op == 2 || op == 6);
    end
    for (int i = 0; i < n; i++) begin
      av = exp_rf[(a + i) % 128];
      bv = imm ? immv : (vec ? exp_rf[(b + i) % 128] : exp_rf[b]);
      if (g == 4'hB) begin
        if (op <= 2) rv = av & bv;
        else if (op <= 5) rv = av ^ bv;
        else rv = av | bv;
      end else begin
        if (op <= 2) rv = av + bv;
        else if (op <= 6) rv = av - bv;
        else rv = bv[31] ? av - bv : av + bv;
      end
      mwr((d + i) % 128, rv);
    end
  endtask

  task automatic compare_all(input string req);
    int bad = 0;
    @(negedge clk);
    for (int r = 0; r < 128; r++) begin
      host_raddr = 7'(r);
      #1;
      if (host_rdata !== exp_rf[r]) begin
        bad++;
        $display("FAIL %s reg %0d: actual=%h expected=%h", req, r, host_rdata, exp_rf[r]);
      end
    end
    tests_run++;
    if (bad != 0) tests_failed++;
  endtask

  task automatic host_write(input int r, input logic [31:0] v);
    @(negedge clk);
    host_we = 1'b1; host_waddr = 7'(r); host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
    mwr(r, v);
  endtask

  task automatic run_op(input logic [31:0] w, input string req, input bit inject);
    int nb = 0; int n; bit legal;
    legal = (w[31:28] == 4'hA) || (w[31:28] == 4'hB);
    n = legal ? int'(w[27:24]) + 1 : 0;
    model(w);
    @(negedge clk);
    instr = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int g = 0; g < 40; g++) begin
      if (!busy) break;
      nb++;
      if (inject && nb == 3) begin
        // R11: host write and a second start while busy must be ignored
        host_we = 1'b1; host_waddr = 7'd100; host_wdata = 32'hDEAD_BEEF;
        start = 1'b1; instr = mk(4'hB, 2, 3'd2, 7'd1, 7'd101, 7'd0);
      end
      @(negedge clk);
      host_we = 1'b0; start = 1'b0;
    end
    check(nb == n, "R10", "busy cycle count", 32'(nb), 32'(n));
    check(done == legal, "R10", "done after last element", {31'd0, done}, {31'd0, legal});
    @(negedge clk);
    check(done == 1'b0, "R10", "done lasts one cycle", {31'd0, done}, 32'd0);
    compare_all(req);
  endtask

  task automatic t_reset;
    for (int r = 0; r < 128; r++) exp_rf[r] = '0;
    check(busy == 1'b0, "R1", "busy after reset", {31'd0, busy}, 32'd0);
    check(done == 1'b0, "R1", "done after reset", {31'd0, done}, 32'd0);
    compare_all("R1");
  endtask

  task automatic t_preload;
    for (int r = 1; r < 48; r++)
      host_write(r, (32'h9E37_79B9 * 32'(r)) ^ 32'(r * 7));
    host_write(0, 32'h1234_5678);  // R2: discarded
    compare_all("R2");
  endtask

  task automatic t_logic;
    run_op(mk(4'hB, 4, 3'd0, 7'd1,  7'd60, 7'd8),  "R4 AND vector", 0);
    run_op(mk(4'hB, 3, 3'd1, 7'd1,  7'd64, 7'd9),  "R4 R7 AND scalar", 0);
    run_op(mk(4'hB, 2, 3'd2, 7'd2,  7'd68, 7'h3F), "R4 AND immediate", 0);
    run_op(mk(4'hB, 3, 3'd3, 7'd3,  7'd70, 7'd12), "R4 XOR vector", 0);
    run_op(mk(4'hB, 3, 3'd4, 7'd3,  7'd74, 7'd13), "R4 XOR scalar", 0);
    run_op(mk(4'hB, 3, 3'd5, 7'd4,  7'd78, 7'h40), "R6 XOR immediate -64", 0);
    run_op(mk(4'hB, 3, 3'd6, 7'd5,  7'd82, 7'd15), "R4 OR vector", 0);
    run_op(mk(4'hB, 3, 3'd7, 7'd5,  7'd86, 7'd16), "R4 OR scalar", 0);
  endtask

  task automatic t_arith;
    run_op(mk(4'hA, 4, 3'd0, 7'd1,  7'd90, 7'd20), "R5 add vector", 0);
    run_op(mk(4'hA, 3, 3'd1, 7'd2,  7'd94, 7'd21), "R5 R7 add scalar", 0);
    run_op(mk(4'hA, 3, 3'd2, 7'd3,  7'd98, 7'h7E), "R6 add immediate -2", 0);
    run_op(mk(4'hA, 3, 3'd4, 7'd4,  7'd102, 7'd22), "R5 subtract vector", 0);
    run_op(mk(4'hA, 3, 3'd5, 7'd5,  7'd106, 7'd23), "R5 subtract scalar", 0);
    run_op(mk(4'hA, 2, 3'd6, 7'd6,  7'd110, 7'd5),  "R5 subtract immediate", 0);
  endtask

  task automatic t_sum;
    run_op(mk(4'hA, 5, 3'd3, 7'd1, 7'd112, 7'd20), "R8 sum", 0);
  endtask

  task automatic t_abs;
    run_op(mk(4'hA, 6, 3'd7, 7'd0, 7'd114, 7'd30), "R9 abs with A=R0", 0);
    run_op(mk(4'hA, 4, 3'd7, 7'd1, 7'd120, 7'd40), "R9 signed add/sub", 0);
  endtask

  task automatic t_wrap;
    run_op(mk(4'hA, 4, 3'd2, 7'd126, 7'd125, 7'd3), "R7 R2 index wrap", 0);
  endtask

  task automatic t_chain;
    run_op(mk(4'hA, 4, 3'd2, 7'd30, 7'd31, 7'd1), "R12 in-place chain", 0);
  endtask

  task automatic t_bad_group;
    run_op(mk(4'hC, 4, 3'd0, 7'd1, 7'd50, 7'd2), "R3 rejected group", 0);
  endtask

  task automatic t_busy_ignore;
    run_op(mk(4'hA, 16, 3'd0, 7'd1, 7'd50, 7'd10), "R11 R3 busy ignore, 16 elements", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_preload;
    t_logic;
    t_arith;
    t_sum;
    t_abs;
    t_wrap;
    t_chain;
    t_bad_group;
    t_busy_ignore;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule